// File: doc/BRIEF.md
# Flag Offset Readback Sequencer

This block returns the two programmable flag thresholds of a FIFO, the almost-empty offset and the almost-full offset, to the reader over the read data bus. The read bus can be narrower than an offset. In that case each offset comes back as a series of slices, least significant slice first. All slices of the almost-empty offset are returned before any slice of the almost-full offset.

A readback step takes place on a rising clock edge only when the active-low read enable and the active-low load strobe are both low. A slice pointer records which slice is next. Each enabled step advances the pointer, and after the last full-offset slice it wraps to the first empty-offset slice. When either strobe goes high, the pointer and the output hold their values, so a read sequence can be interleaved with ordinary FIFO traffic and then picked up where it stopped.

Each enabled step loads the read data register, which replaces the data word held there before. The bus-width code is treated as static and is captured only during reset. The block has no timing-mode input, so it behaves the same under standard and first-word-fall-through operation.

Top module: `flag_ofs_readback`

## Requirements
- R1: While `rst` is high on a clock edge, `rd_data` clears to zero and the slice pointer returns to the first slice of the almost-empty offset.
- R2: A step happens only on an edge where `rd_en_n` and `ld_n` are both low. On any other edge `rd_data` keeps its value.
- R3: Width code 0 gives one slice per offset. Successive enabled steps return the whole empty offset, then the whole full offset. Code 3 behaves exactly like code 0.
- R4: Width code 1 gives slices of ceil(OFS_W/2) bits. The order is empty bits [8:0], empty bits [17:9], full bits [8:0], full bits [17:9] (shown for OFS_W=18).
- R5: Width code 2 gives slices of ceil(OFS_W/3) bits, three per offset. The order is empty bits [5:0], [11:6], [17:12], then full bits [5:0], [11:6], [17:12] (shown for OFS_W=18).
- R6: The enabled step that follows the last full-offset slice returns the first empty-offset slice.
- R7: Raising `rd_en_n`, `ld_n` or both leaves the slice pointer unchanged. The next enabled step returns the slice that would have come next with no pause.
- R8: `width_sel` is captured only while `rst` is high. A change after reset does not alter the slicing until the next reset.
- R9: A slice is placed in the low bits of `rd_data`, and all bits above the slice width are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en_n | input | 1 | Active-low read enable |
| ld_n | input | 1 | Active-low load strobe that selects offset access |
| width_sel | input | 2 | Bus-width code: 0 or 3 full, 1 half, 2 third |
| empty_ofs | input | OFS_W | Almost-empty offset value |
| full_ofs | input | OFS_W | Almost-full offset value |
| rd_data | output | OFS_W | Read data register |

## Verification
The bench targets the wrap after the last full slice in each of the three widths. A pointer that miscounts the last index would instead return a stale or out-of-range slice, or a slice from the full offset. It pauses the sequence with each strobe alone and with both together. A design that advanced on a single low strobe would skip a slice on resume, and one that reloaded the output would change `rd_data` while paused. It also changes the width code after reset and reads a mid-word slice under the half and third widths. Sampling the code at every cycle, or leaving stray upper bits, then shows up directly on `rd_data`.

// File: rtl/flag_ofs_readback_pkg.sv
package flag_ofs_readback_pkg;

    typedef enum logic [1:0] {
        BW_FULL  = 2'd0,
        BW_HALF  = 2'd1,
        BW_THIRD = 2'd2
    } bus_width_e;

    typedef struct packed {
        logic       in_full;
        logic [1:0] idx;
    } slice_ptr_t;

    function automatic bus_width_e decode_width(input logic [1:0] code);
        case (code)
            2'd1:    return BW_HALF;
            2'd2:    return BW_THIRD;
            default: return BW_FULL;
        endcase
    endfunction

    function automatic logic [1:0] last_idx(input bus_width_e w);
        case (w)
            BW_HALF:  return 2'd1;
            BW_THIRD: return 2'd2;
            default:  return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/flag_ofs_readback_width_latch.sv
module flag_ofs_readback_width_latch
    import flag_ofs_readback_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] width_sel,
    output bus_width_e width_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            width_q <= decode_width(width_sel);
        end
    end
endmodule

// File: rtl/flag_ofs_readback_slice_ptr.sv
module flag_ofs_readback_slice_ptr
    import flag_ofs_readback_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       step,
    input  bus_width_e width_q,
    output slice_ptr_t ptr
);
    logic at_last;
    assign at_last = (ptr.idx == last_idx(width_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (step) begin
            if (at_last) begin
                ptr.idx     <= 2'd0;
                ptr.in_full <= ~ptr.in_full;
            end else begin
                ptr.idx <= 2'(ptr.idx + 2'd1);
            end
        end
    end
endmodule

// File: rtl/flag_ofs_readback_slice_mux.sv
module flag_ofs_readback_slice_mux
    import flag_ofs_readback_pkg::*;
#(
    parameter int OFS_W = 18
) (
    input  slice_ptr_t       ptr,
    input  bus_width_e       width_q,
    input  logic [OFS_W-1:0] empty_ofs,
    input  logic [OFS_W-1:0] full_ofs,
    output logic [OFS_W-1:0] slice_out
);
    localparam int HALF_W  = (OFS_W + 1) / 2;
    localparam int THIRD_W = (OFS_W + 2) / 3;
    localparam int HPAD_W  = 2 * HALF_W;
    localparam int TPAD_W  = 3 * THIRD_W;

    logic [OFS_W-1:0]  src;
    logic [HPAD_W-1:0] src_h;
    logic [TPAD_W-1:0] src_t;
    logic [OFS_W-1:0]  half_pc  [2];
    logic [OFS_W-1:0]  third_pc [3];

    assign src   = ptr.in_full ? full_ofs : empty_ofs;
    assign src_h = HPAD_W'(src);
    assign src_t = TPAD_W'(src);

    for (genvar g = 0; g < 2; g++) begin : g_half
        assign half_pc[g] = OFS_W'(src_h[g*HALF_W +: HALF_W]);
    end

    for (genvar g = 0; g < 3; g++) begin : g_third
        assign third_pc[g] = OFS_W'(src_t[g*THIRD_W +: THIRD_W]);
    end

    always_comb begin
        case (width_q)
            BW_HALF:  slice_out = half_pc[ptr.idx[0]];
            BW_THIRD: slice_out = (ptr.idx == 2'd3) ? '0 : third_pc[ptr.idx];
            default:  slice_out = src;
        endcase
    end
endmodule

// File: rtl/flag_ofs_readback.sv
module flag_ofs_readback
    import flag_ofs_readback_pkg::*;
#(
    parameter int OFS_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en_n,
    input  logic             ld_n,
    input  logic [1:0]       width_sel,
    input  logic [OFS_W-1:0] empty_ofs,
    input  logic [OFS_W-1:0] full_ofs,
    output logic [OFS_W-1:0] rd_data
);
    bus_width_e       width_q;
    slice_ptr_t       ptr;
    logic             step;
    logic [OFS_W-1:0] slice_val;

    assign step = ~rd_en_n & ~ld_n;

    flag_ofs_readback_width_latch u_width (
        .clk       (clk),
        .rst       (rst),
        .width_sel (width_sel),
        .width_q   (width_q)
    );

    flag_ofs_readback_slice_ptr u_ptr (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .width_q (width_q),
        .ptr     (ptr)
    );

    flag_ofs_readback_slice_mux #(.OFS_W(OFS_W)) u_mux (
        .ptr       (ptr),
        .width_q   (width_q),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs),
        .slice_out (slice_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (step) begin
            rd_data <= slice_val;
        end
    end
endmodule

// File: rtl/flag_ofs_readback_checker.sv
module flag_ofs_readback_checker
    import flag_ofs_readback_pkg::*;
#(
    parameter int OFS_W = 18
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_en_n,
    input logic             ld_n,
    input logic [OFS_W-1:0] rd_data,
    input bus_width_e       width_q,
    input slice_ptr_t       ptr
);
    localparam int HALF_W  = (OFS_W + 1) / 2;
    localparam int THIRD_W = (OFS_W + 2) / 3;

    logic enabled;
    assign enabled = !rd_en_n && !ld_n;

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (ptr == '0 && rd_data == '0));

    a_r2_hold_data: assert property (@(posedge clk) disable iff (rst)
        !enabled |=> $stable(rd_data));

    a_r7_hold_ptr: assert property (@(posedge clk) disable iff (rst)
        !enabled |=> $stable(ptr));

    a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
        (enabled && ptr.in_full && ptr.idx == last_idx(width_q)) |=> (ptr == '0));

    // R4 R5
    a_r4_idx_range: assert property (@(posedge clk) disable iff (rst)
        ptr.idx <= last_idx(width_q));

    a_r8_width_static: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(width_q));

    a_r9_half_zero_ext: assert property (@(posedge clk) disable iff (rst)
        (width_q == BW_HALF) |-> ((rd_data >> HALF_W) == '0));

    a_r9_third_zero_ext: assert property (@(posedge clk) disable iff (rst)
        (width_q == BW_THIRD) |-> ((rd_data >> THIRD_W) == '0));
endmodule

bind flag_ofs_readback flag_ofs_readback_checker #(.OFS_W(OFS_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_en_n (rd_en_n),
    .ld_n    (ld_n),
    .rd_data (rd_data),
    .width_q (width_q),
    .ptr     (ptr)
);

// File: tb/flag_ofs_readback_tb_top.sv
`timescale 1ns/1ps
module flag_ofs_readback_tb_top;
    localparam int OFS_W = 18;

    logic             clk = 1'b0;
    logic             rst = 1'b0;
    logic             rd_en_n = 1'b1;
    logic             ld_n = 1'b1;
    logic [1:0]       width_sel = 2'd0;
    logic [OFS_W-1:0] empty_ofs = 18'h2A5C3;
    logic [OFS_W-1:0] full_ofs  = 18'h1B7E9;
    logic [OFS_W-1:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    flag_ofs_readback #(.OFS_W(OFS_W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .rd_en_n   (rd_en_n),
        .ld_n      (ld_n),
        .width_sel (width_sel),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs),
        .rd_data   (rd_data)
    );

    function automatic logic [17:0] exp_half(input logic [17:0] v, input int i);
        return (i == 0) ? {9'b0, v[8:0]} : {9'b0, v[17:9]};
    endfunction

    function automatic logic [17:0] exp_third(input logic [17:0] v, input int i);
        return {12'b0, v[6*i +: 6]};
    endfunction

    task automatic check(input logic [17:0] exp, input string req);
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s: rd_data=%h expected %h", req, rd_data, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] sel);
        @(negedge clk);
        rst = 1'b1; rd_en_n = 1'b1; ld_n = 1'b1; width_sel = sel;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic rd_step(input logic [17:0] exp, input string req);
        rd_en_n = 1'b0; ld_n = 1'b0;
        @(negedge clk);
        check(exp, req);
    endtask

    task automatic idle(input logic en_n, input logic l_n, input int n, input logic [17:0] exp);
        rd_en_n = en_n; ld_n = l_n;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check(exp, "R2 pause hold");
        end
    endtask

    task automatic t_reset_state;
        rd_en_n = 1'b0; ld_n = 1'b0;
        @(negedge clk);
        rst = 1'b1; width_sel = 2'd0;
        @(negedge clk);
        rst = 1'b0; rd_en_n = 1'b1; ld_n = 1'b1;
        check(18'h0, "R1 reset data");
        rd_step(empty_ofs, "R1 first after reset");
        idle(1'b1, 1'b1, 1, empty_ofs);
    endtask

    task automatic t_full_mode(input logic [1:0] code);
        do_reset(code);
        rd_step(empty_ofs, "R3 empty");
        rd_step(full_ofs,  "R3 full");
        rd_step(empty_ofs, "R6 wrap full");
        idle(1'b1, 1'b1, 1, empty_ofs);
    endtask

    task automatic t_half_mode;
        do_reset(2'd1);
        rd_step(exp_half(empty_ofs, 0), "R4 R9 empty lo");
        rd_step(exp_half(empty_ofs, 1), "R4 R9 empty hi");
        rd_step(exp_half(full_ofs, 0),  "R4 full lo");
        rd_step(exp_half(full_ofs, 1),  "R4 full hi");
        rd_step(exp_half(empty_ofs, 0), "R6 wrap half");
        idle(1'b1, 1'b1, 1, exp_half(empty_ofs, 0));
    endtask

    task automatic t_third_mode;
        do_reset(2'd2);
        for (int i = 0; i < 3; i++) rd_step(exp_third(empty_ofs, i), "R5 R9 empty");
        for (int i = 0; i < 3; i++) rd_step(exp_third(full_ofs, i), "R5 full");
        rd_step(exp_third(empty_ofs, 0), "R6 wrap third");
        idle(1'b1, 1'b1, 1, exp_third(empty_ofs, 0));
    endtask

    task automatic t_pause;
        do_reset(2'd2);
        rd_step(exp_third(empty_ofs, 0), "R7 before pause");
        idle(1'b1, 1'b0, 2, exp_third(empty_ofs, 0));
        rd_step(exp_third(empty_ofs, 1), "R7 resume after rd_en_n");
        idle(1'b0, 1'b1, 2, exp_third(empty_ofs, 1));
        rd_step(exp_third(empty_ofs, 2), "R7 resume after ld_n");
        idle(1'b1, 1'b1, 3, exp_third(empty_ofs, 2));
        rd_step(exp_third(full_ofs, 0), "R7 resume after both");
        idle(1'b1, 1'b1, 1, exp_third(full_ofs, 0));
    endtask

    task automatic t_width_static;
        do_reset(2'd1);
        width_sel = 2'd0;
        @(negedge clk);
        rd_step(exp_half(empty_ofs, 0), "R8 width kept lo");
        width_sel = 2'd2;
        rd_step(exp_half(empty_ofs, 1), "R8 width kept hi");
        idle(1'b1, 1'b1, 1, exp_half(empty_ofs, 1));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: rd_data=%h expected completion", rd_data);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_full_mode(2'd0);
        t_full_mode(2'd3);
        t_half_mode();
        t_third_mode();
        t_pause();
        empty_ofs = 18'h3F03C; full_ofs = 18'h00FC1;
        t_half_mode();
        t_third_mode();
        t_width_static();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule